// File: doc/BRIEF.md
# Linked-Table Address Translator

This block sits between a trace writer and the memory system and turns the writer's linear input addresses into physical addresses. Memory holds a chain of 4 KB table pages. Each table page maps one 1 MB slice of input space through 256 entries, one entry per 4 KB data page. Two link entries near the end of every table page point to the previous table and to the next table. The translator keeps the base of the table it used last and moves along the chain one link at a time until it reaches the table that covers the request. Each move costs one 64-bit read.

Software programs a mode, a table base and an input base while the block is disabled, and then sets enable. In pass-through mode, requests come back unchanged and memory is not read. In translate mode, each request reads one data-page entry, plus one read for every link it follows. The response then carries either the translated address or a fault. A sticky error flag records every fault, and a ready flag shows when no walk is in progress.

Top module: `chain_xlat`

## Requirements
- R1: After reset, the status register (config address 4) reads ready=1 in bit 0 and error=0 in bit 1. The block is disabled, so `req_ready` is low, and the table base register (address 2) reads zero.
- R2: With enable set (address 0, bit 0) and the mode bit clear (address 1, bit 0 = 0), an accepted request returns on the next cycle as `rsp_valid` with `rsp_fault` low and the input address zero-extended. No memory read is made.
- R3: While enable is set, writes to the mode register (1), the table base register (2) and the input base register (3) have no effect.
- R4: In translate mode (mode bit = 1), the offset is the request address minus the input base. The input base is forced to a 1 MB boundary. Offset bits 19..12 select the entry, which is read at the current table base plus 8 times the entry number. The result is entry bits 39..12 joined with request bits 11..0. When the current table already covers the offset, exactly one read is made.
- R5: When the offset's table number (offset bits 31..20) is above the current one, the block reads entry 511 (byte offset 0xFF8) of each table to move forward. Each hop is one read.
- R6: When the table number is below the current one, the block reads entry 510 (byte offset 0xFF0) of each table to move backward. Each hop is one read.
- R7: An entry with bit 0 clear ends the request with `rsp_fault` high and `rsp_addr` zero.
- R8: A link with bit 0 clear that must be followed gives a fault response. A request address below the input base gives a fault response without any memory read.
- R9: Every fault sets status bit 1, which stays set until a write to address 4 with bit 1 set. Status bit 0 reads 0 while a walk is in progress, and no new request is accepted then.
- R10: Clearing enable discards the current table. The first translation after enable is set again starts from the table base as table 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Config register write strobe |
| cfg_rd | input | 1 | Config register read strobe |
| cfg_addr | input | 3 | Config register address |
| cfg_wdata | input | 64 | Config write data |
| cfg_rdata | output | 64 | Config read data, valid the cycle after `cfg_rd` |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_addr | input | IAW | Input address to translate |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | Response is a fault |
| rsp_addr | output | PW | Translated (or passed-through) address |
| mem_req | output | 1 | One-cycle table read request |
| mem_addr | output | PW | Byte address of the 64-bit table word |
| mem_rvalid | input | 1 | Table read data valid |
| mem_rdata | input | 64 | Table read data |

## Verification
The bench goes after the walk direction and the hop count. It jumps forward two tables, back one, and stays in place, and it counts reads at the memory port for each case. A walker that indexes the wrong link slot, or that forgets the table it used last, returns wrong addresses or shows extra reads. The bench also drives an invalid trailing entry, a missing end link and an address below the base. A design that skips a valid check would return a non-zero address with no fault. Finally, the bench disables and re-enables the block between far-apart tables. A design that keeps the old table would make three reads instead of one.

// File: rtl/lxl_pkg.sv
package lxl_pkg;
  localparam int PAGE_SH   = 12;
  localparam int REGION_SH = 20;
  localparam int IDX_W     = REGION_SH - PAGE_SH;

  typedef enum logic [1:0] {W_IDLE, W_STEP, W_LINK, W_ENTRY} walk_st_t;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_MODE  = 3'd1;
  localparam logic [2:0] RA_TBASE = 3'd2;
  localparam logic [2:0] RA_IBASE = 3'd3;
  localparam logic [2:0] RA_STAT  = 3'd4;

  localparam logic [8:0] SLOT_BACK = 9'd510;
  localparam logic [8:0] SLOT_FWD  = 9'd511;
endpackage

// File: rtl/lxl_regs.sv
module lxl_regs #(
  parameter int IAW = 32,
  parameter int PW  = 40
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [2:0]     addr,
  input  logic [63:0]    wdata,
  output logic [63:0]    rdata,
  input  logic           walk_busy,
  input  logic           fault_evt,
  output logic           en,
  output logic           xlate,
  output logic [PW-1:0]  tbase,
  output logic [IAW-1:0] ibase
);
  import lxl_pkg::*;

  logic err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= 1'b0;
      xlate <= 1'b0;
      tbase <= '0;
      ibase <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          RA_CTRL:  en <= wdata[0];
          RA_MODE:  if (!en) xlate <= wdata[0];
          RA_TBASE: if (!en) tbase <= {wdata[PW-1:PAGE_SH], {PAGE_SH{1'b0}}};
          RA_IBASE: if (!en) ibase <= {wdata[IAW-1:REGION_SH], {REGION_SH{1'b0}}};
          RA_STAT:  if (wdata[1]) err_q <= 1'b0;
          default: ;
        endcase
      end
      if (fault_evt) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        RA_CTRL:  rdata <= {63'd0, en};
        RA_MODE:  rdata <= {63'd0, xlate};
        RA_TBASE: rdata <= 64'(tbase);
        RA_IBASE: rdata <= 64'(ibase);
        RA_STAT:  rdata <= {62'd0, err_q, ~walk_busy};
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/lxl_walk.sv
module lxl_walk #(
  parameter int IAW = 32,
  parameter int PW  = 40
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           xlate,
  input  logic [PW-1:0]  tbase,
  input  logic [IAW-1:0] ibase,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [IAW-1:0] req_addr,
  output logic           rsp_valid,
  output logic           rsp_fault,
  output logic [PW-1:0]  rsp_addr,
  output logic           mem_req,
  output logic [PW-1:0]  mem_addr,
  input  logic           mem_rvalid,
  input  logic [63:0]    mem_rdata,
  output logic           busy,
  output logic           fault_evt
);
  import lxl_pkg::*;

  localparam int TNW = IAW - REGION_SH;
  localparam int BW  = PW - PAGE_SH;

  walk_st_t             st;
  logic [BW-1:0]        cur_base;
  logic [TNW-1:0]       cur_num;
  logic                 cache_vld;
  logic [TNW-1:0]       tgt;
  logic [IDX_W-1:0]     idx;
  logic [PAGE_SH-1:0]   low;
  logic                 go_fwd;
  logic [IAW-1:0]       offset;
  logic                 take;

  assign offset    = req_addr - ibase;
  assign req_ready = en && (st == W_IDLE);
  assign take      = req_valid && req_ready;
  assign busy      = (st != W_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= W_IDLE;
      cur_base  <= '0;
      cur_num   <= '0;
      cache_vld <= 1'b0;
      tgt       <= '0;
      idx       <= '0;
      low       <= '0;
      go_fwd    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_addr  <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      fault_evt <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      mem_req   <= 1'b0;
      fault_evt <= 1'b0;
      case (st)
        W_IDLE: if (take) begin
          if (!xlate) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_addr  <= PW'(req_addr);
          end else if (req_addr < ibase) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_addr  <= '0;
            fault_evt <= 1'b1;
          end else begin
            tgt <= offset[IAW-1:REGION_SH];
            idx <= offset[REGION_SH-1:PAGE_SH];
            low <= req_addr[PAGE_SH-1:0];
            if (!cache_vld) begin
              cur_base  <= tbase[PW-1:PAGE_SH];
              cur_num   <= '0;
              cache_vld <= 1'b1;
            end
            st <= W_STEP;
          end
        end
        W_STEP: begin
          mem_req <= 1'b1;
          if (tgt > cur_num) begin
            mem_addr <= {cur_base, SLOT_FWD, 3'b000};
            go_fwd   <= 1'b1;
            st       <= W_LINK;
          end else if (tgt < cur_num) begin
            mem_addr <= {cur_base, SLOT_BACK, 3'b000};
            go_fwd   <= 1'b0;
            st       <= W_LINK;
          end else begin
            mem_addr <= {cur_base, 1'b0, idx, 3'b000};
            st       <= W_ENTRY;
          end
        end
        W_LINK: if (mem_rvalid) begin
          if (!mem_rdata[0]) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_addr  <= '0;
            fault_evt <= 1'b1;
            st        <= W_IDLE;
          end else begin
            cur_base <= mem_rdata[PW-1:PAGE_SH];
            cur_num  <= go_fwd ? cur_num + 1'b1 : cur_num - 1'b1;
            st       <= W_STEP;
          end
        end
        W_ENTRY: if (mem_rvalid) begin
          rsp_valid <= 1'b1;
          st        <= W_IDLE;
          if (!mem_rdata[0]) begin
            rsp_fault <= 1'b1;
            rsp_addr  <= '0;
            fault_evt <= 1'b1;
          end else begin
            rsp_fault <= 1'b0;
            rsp_addr  <= {mem_rdata[PW-1:PAGE_SH], low};
          end
        end
        default: st <= W_IDLE;
      endcase
      if (!en) cache_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/chain_xlat.sv
module chain_xlat #(
  parameter int IAW = 32,
  parameter int PW  = 40
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic           cfg_rd,
  input  logic [2:0]     cfg_addr,
  input  logic [63:0]    cfg_wdata,
  output logic [63:0]    cfg_rdata,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [IAW-1:0] req_addr,
  output logic           rsp_valid,
  output logic           rsp_fault,
  output logic [PW-1:0]  rsp_addr,
  output logic           mem_req,
  output logic [PW-1:0]  mem_addr,
  input  logic           mem_rvalid,
  input  logic [63:0]    mem_rdata
);
  logic           en_w;
  logic           xlate_w;
  logic [PW-1:0]  tbase_w;
  logic [IAW-1:0] ibase_w;
  logic           busy_w;
  logic           fault_w;

  lxl_regs #(.IAW(IAW), .PW(PW)) regs_i (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .rd_en(cfg_rd), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .walk_busy(busy_w),
    .fault_evt(fault_w), .en(en_w), .xlate(xlate_w), .tbase(tbase_w),
    .ibase(ibase_w)
  );

  lxl_walk #(.IAW(IAW), .PW(PW)) walk_i (
    .clk(clk), .rst(rst), .en(en_w), .xlate(xlate_w), .tbase(tbase_w),
    .ibase(ibase_w), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_addr(rsp_addr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .busy(busy_w),
    .fault_evt(fault_w)
  );
endmodule

// File: rtl/chain_xlat_chk.sv
module chain_xlat_chk #(
  parameter int IAW = 32,
  parameter int PW  = 40
) (
  input logic           clk,
  input logic           rst,
  input logic           cfg_wr,
  input logic [2:0]     cfg_addr,
  input logic           en_w,
  input logic           xlate_w,
  input logic [IAW-1:0] ibase_w,
  input logic           busy_w,
  input logic           req_valid,
  input logic           req_ready,
  input logic [IAW-1:0] req_addr,
  input logic           rsp_valid,
  input logic           rsp_fault,
  input logic [PW-1:0]  rsp_addr,
  input logic           mem_req,
  input logic [PW-1:0]  mem_addr
);
  // R2
  passthru_echo_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !xlate_w) |=>
      (rsp_valid && !rsp_fault && rsp_addr == PW'($past(req_addr))));

  // R3
  mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && en_w && cfg_addr == 3'd1) |=> $stable(xlate_w));

  // R4
  word_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[2:0] == 3'b000));

  // R5
  one_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R7
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_addr == '0));

  // R8
  below_base_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && xlate_w && req_addr < ibase_w) |=>
      (rsp_valid && rsp_fault));

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (busy_w && !req_ready));
endmodule

bind chain_xlat chain_xlat_chk #(.IAW(IAW), .PW(PW)) chk_i (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .en_w(en_w),
  .xlate_w(xlate_w), .ibase_w(ibase_w), .busy_w(busy_w),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr),
  .mem_req(mem_req), .mem_addr(mem_addr)
);

// File: tb/chain_xlat_tb_top.sv
`timescale 1ns/1ps
module chain_xlat_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_fault;
  logic [39:0] rsp_addr;
  logic        mem_req;
  logic [39:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;

  int n_chk = 0, n_fail = 0, nreads = 0;

  localparam logic [63:0] DATA0 = 64'h50_0000_0000;
  localparam logic [31:0] IB    = 32'h0010_0000;

  always #4 clk = ~clk;

  chain_xlat dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_addr(rsp_addr), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [63:0] tbl(input int t);
    return 64'h0000_A000 + 64'(t) * 64'h2000;
  endfunction

  // three chained tables; the last maps only 16 pages and has no forward link
  function automatic logic [63:0] mem_word(input logic [39:0] a);
    int t, i;
    t = -1;
    for (int k = 0; k < 3; k++)
      if (64'(a[39:12]) == (tbl(k) >> 12)) t = k;
    i = int'(a[11:3]);
    if (t < 0) return 64'd0;
    if (i < 256) begin
      if (t == 2 && i >= 16) return 64'd0;
      return (DATA0 + 64'((t * 256 + i) * 4096)) | 64'd1;
    end
    if (i == 510) return (t == 0) ? 64'd0 : (tbl(t - 1) | 64'd1);
    if (i == 511) return (t == 2) ? 64'd0 : (tbl(t + 1) | 64'd1);
    return 64'd0;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    if (mem_req) mem_rdata <= mem_word(mem_addr);
  end

  always @(negedge clk) if (mem_req) nreads++;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    @(negedge clk); cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk); cfg_rd = 1'b0; d = cfg_rdata;
  endtask

  task automatic xlat(input logic [31:0] a, output logic flt, output logic [39:0] oa,
                      output int reads, output int lat);
    int w;
    logic got;
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    w = 0;
    while (!req_ready && w < 50) begin @(negedge clk); w++; end
    nreads = 0;
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    got = 1'b0; flt = 1'bx; oa = 'x; lat = -1;
    for (int i = 0; i < 100 && !got; i++) begin
      if (rsp_valid) begin got = 1'b1; flt = rsp_fault; oa = rsp_addr; lat = i; end
      else @(negedge clk);
    end
    reads = nreads;
  endtask

  task automatic run_xl(input string tag, input logic [31:0] a, input logic exp_f,
                        input logic [39:0] exp_a, input int exp_reads);
    logic f; logic [39:0] o; int r, l;
    xlat(a, f, o, r, l);
    chk({tag, " fault"}, 64'(f), 64'(exp_f));
    chk({tag, " addr"}, 64'(o), 64'(exp_a));
    chk({tag, " reads"}, 64'(r), 64'(exp_reads));
  endtask

  task automatic t_reset;
    logic [63:0] d;
    rd(3'd4, d); chk("R1 status", d, 64'h1);
    rd(3'd2, d); chk("R1 tbase", d, 64'h0);
    chk("R1 req_ready", 64'(req_ready), 64'h0);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'h0);
  endtask

  task automatic t_pass;
    logic f; logic [39:0] o; int r, l;
    wr(3'd1, 64'h0); wr(3'd0, 64'h1);
    xlat(32'h1234_5678, f, o, r, l);
    chk("R2 addr", 64'(o), 64'h12_3456_78);
    chk("R2 fault", 64'(f), 64'h0);
    chk("R2 no read", 64'(r), 64'h0);
    chk("R2 next cycle", 64'(l), 64'h0);
  endtask

  task automatic t_lock;
    logic [63:0] d;
    wr(3'd1, 64'h1); wr(3'd2, tbl(0)); wr(3'd3, 64'(IB));
    rd(3'd1, d); chk("R3 mode held", d, 64'h0);
    rd(3'd2, d); chk("R3 tbase held", d, 64'h0);
    rd(3'd3, d); chk("R3 ibase held", d, 64'h0);
    run_xl("R3 still passthru", 32'h0030_0010, 1'b0, 40'h00_0030_0010, 0);
  endtask

  task automatic t_setup;
    logic [63:0] d;
    wr(3'd0, 64'h0);
    wr(3'd1, 64'h1); wr(3'd2, tbl(0)); wr(3'd3, 64'(IB) | 64'h1234);
    rd(3'd3, d); chk("R4 ibase aligned", d, 64'(IB));
    rd(3'd4, d); chk("R9 ready before enable", d, 64'h1);
    wr(3'd0, 64'h1);
  endtask

  task automatic t_walk;
    logic [63:0] d;
    run_xl("R4 table0", 32'h0010_3ABC, 1'b0, 40'h50_0000_3ABC, 1);
    fork
      run_xl("R5 forward", 32'h0030_0010, 1'b0, 40'h50_0020_0010, 3);
      begin
        @(negedge clk); @(negedge clk);
        rd(3'd4, d); chk("R9 ready low in walk", d & 64'h1, 64'h0);
      end
    join
    run_xl("R6 backward", 32'h0020_1FFF, 1'b0, 40'h50_0010_1FFF, 2);
    run_xl("R4 same table", 32'h0020_2004, 1'b0, 40'h50_0010_2004, 1);
  endtask

  task automatic t_faults;
    logic [63:0] d;
    run_xl("R7 bad entry", 32'h0031_4000, 1'b1, 40'h0, 2);
    rd(3'd4, d); chk("R9 sticky err", d, 64'h3);
    run_xl("R8 bad link", 32'h0040_0000, 1'b1, 40'h0, 1);
    run_xl("R8 below base", 32'h000F_FFFF, 1'b1, 40'h0, 0);
    wr(3'd4, 64'h2);
    rd(3'd4, d); chk("R9 err cleared", d, 64'h1);
  endtask

  task automatic t_reenable;
    wr(3'd0, 64'h0); wr(3'd0, 64'h1);
    run_xl("R10 restart at base", 32'h0010_0000, 1'b0, 40'h50_0000_0000, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_pass;
    t_lock;
    t_setup;
    t_walk;
    t_faults;
    t_reenable;
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule